// File: doc/BRIEF.md
# Dual-Channel 8-bit Compare Timer with PWM

This block is an 8-bit timer/counter. One counter feeds two compare channels, A and B. Each channel has its own compare value, its own waveform pin and its own match flag. An overflow flag completes the set of three interrupt requests.

The counter runs in one of four modes:

- Free counting.
- Clear on a channel-A match, which gives a variable period.
- Single-slope fast PWM.
- Dual-slope phase-correct PWM.

A three-bit selector chooses what advances the counter:

- Nothing (stopped).
- Every clock.
- One of four prescaler strobes, each one cycle wide.
- A falling or a rising edge on an external pin. The pin is synchronised through two flops, and each edge then counts exactly once.

Software configures the block through a one-cycle write port. Each write carries an address and a data byte, and no write is ever refused. Because no data stream flows in or out, the block has no back-pressure. While the power-down input is high, the block freezes: the counter, the compare logic, the flags, the synchroniser and the registers all hold. Write attempts made in that time are dropped.

In the two PWM modes, compare values are double-buffered: a write goes to a holding register first. That register is copied into the active compare register only at the end of the period: at the top in fast PWM, and on reaching zero in phase-correct PWM. This keeps every pulse whole. The current count is available on an output.

Top module: `tmr8_dualcmp`

## Requirements
- R1: After reset, the count, the three flags and both waveform pins are 0. The active compare values are 0 and the mode is free counting with the counter stopped.
- R2: Write-port fields:
  - Address 0: bits [2:0] select the count source, and bits [4:3] select the mode.
  - Count source 0 stops the counter and 1 advances it every clock.
  - Sources 2, 3, 4 and 5 advance it on strobe bits 0, 1, 2 and 3 respectively; strobes on other bits are ignored.
  - Source 6 advances it once per falling edge of the external pin, and source 7 once per rising edge. The pin is synchronised through two flops first.
- R3: Mode 0 (free counting) increments the count and wraps from 255 to 0. The overflow flag (flag bit 0) is set on the wrap.
- R4: Mode 1 (clear on match): an advance taken while the count equals compare A loads 0 into the counter, so the period is compare A + 1 advances.
- R5: Mode 2 (fast PWM):
  - The count wraps 255 to 0 and the overflow flag is set on the wrap.
  - Compare writes (address 2 for A, address 3 for B) reach the active register only on the wrap.
  - Output mode 2 sets the pin on the wrap and clears it on a match. Output mode 3 does the opposite.
- R6: Mode 3 (phase-correct PWM):
  - The count goes from 0 up to 255 and then down to 0, turning at each end.
  - The overflow flag is set and the buffered compare values are loaded on arriving at 0.
  - Output mode 2 clears the pin on a match while counting up and sets it on a match while counting down. Output mode 3 does the opposite.
- R7: A match occurs on an advance taken while the count equals that channel's active compare value. The match sets that channel's flag (bit 1 for A, bit 2 for B) one cycle later; each flag is set independently of the others.
- R8: Writing to address 5 clears each flag whose data bit is 1. A 0 data bit leaves its flag unchanged.
- R9: In modes 0 and 1, a compare write becomes active on the next cycle. Address 1 holds the output modes: bits [1:0] for A and [3:2] for B.
  - Output mode 0 keeps the pin low.
  - Output modes 1, 2 and 3 toggle, clear and set the pin on a match, respectively.
  - In the PWM modes, output modes 0 and 1 keep the pin low.
- R10: While the power-down input is high, the count, the flags and the pins hold, and writes are ignored. Counting resumes where it stopped once the input falls.
- R11: A write to address 4 loads the counter and takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_off | input | 1 | Power-down; high freezes the block |
| pre_stb | input | 4 | Prescaler strobes, one cycle wide each |
| ext_pin | input | 1 | External count input, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| irq_ovf | output | 1 | Overflow / bottom flag |
| irq_cmpa | output | 1 | Channel A match flag |
| irq_cmpb | output | 1 | Channel B match flag |

## Verification
The bench builds the block with its default values: an 8-bit counter and a 3-bit address. At this width, a full 256-step fast-PWM period and the 510-step phase-correct cycle both complete within a few hundred clocks when the every-clock source is selected.

That brings several cases within reach of directed tests:
- The wrap at 255.
- The turn at the top and at zero.
- The point where the buffered compare value takes effect.

The bench also confirms that a stale compare value keeps matching until the buffered value is loaded.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    M_NORMAL = 2'd0,
    M_CTC    = 2'd1,
    M_FAST   = 2'd2,
    M_PHASE  = 2'd3
  } mode_e;

  localparam int PRE_TAPS = 4;
  localparam int NCH      = 2;

  localparam int A_CTRL = 0;
  localparam int A_OUTM = 1;
  localparam int A_CMPA = 2;
  localparam int A_CNT  = 4;
  localparam int A_FLAG = 5;
endpackage

// File: rtl/tmr8_tick.sv
module tmr8_tick
  import tmr8_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [2:0]          csel,
  input  logic [PRE_TAPS-1:0] pre_stb,
  input  logic                ext_pin,
  output logic                tick
);
  localparam int TAP_W = $clog2(PRE_TAPS);

  // [0],[1] synchroniser, [2] previous synchronised value
  logic [2:0]       sync_q;
  logic             rise, fall, sel;
  logic [TAP_W-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sync_q <= '0;
    else if (run) sync_q <= {sync_q[1:0], ext_pin};
  end

  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];
  assign tap  = TAP_W'(csel - 3'd2);

  always_comb begin
    case (csel)
      3'd0:    sel = 1'b0;
      3'd1:    sel = 1'b1;
      3'd6:    sel = fall;
      3'd7:    sel = rise;
      default: sel = pre_stb[tap];
    endcase
  end

  assign tick = run & sel;

  // R2: an edge source cannot advance the counter twice in a row
  p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 3'd7) && tick |=> (csel != 3'd7) || !tick);
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  mode_e        mode,
  input  logic [W-1:0] top_val,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt,
  output logic         dir_dn,
  output logic         ovf_evt,
  output logic         load_evt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic step, at_max, at_low;

  assign step   = run & tick;
  assign at_max = (cnt == MAX);
  assign at_low = (cnt <= ONE);

  assign ovf_evt  = step && ((mode == M_PHASE) ? (dir_dn && at_low) : at_max);
  assign load_evt = step && (((mode == M_FAST) && at_max) ||
                             ((mode == M_PHASE) && dir_dn && at_low));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_dn <= 1'b0;
    end else if (run) begin
      if (cnt_wr) begin
        cnt <= cnt_wdata;
      end else if (tick) begin
        case (mode)
          M_CTC:   cnt <= (cnt == top_val) ? '0 : cnt + ONE;
          M_PHASE: begin
            if (dir_dn) begin
              if (at_low) begin
                cnt    <= '0;
                dir_dn <= 1'b0;
              end else begin
                cnt <= cnt - ONE;
              end
            end else if (cnt >= MAX - ONE) begin
              cnt    <= MAX;
              dir_dn <= 1'b1;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          default: cnt <= cnt + ONE;
        endcase
      end
      if (mode != M_PHASE) dir_dn <= 1'b0;
    end
  end

  // R4: a match with compare A reloads zero
  p_ctc_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && !cnt_wr && (mode == M_CTC) && (cnt == top_val) |=> cnt == '0);
  // R6: counting up in phase-correct mode below the top moves by exactly one
  p_phase_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && !cnt_wr && (mode == M_PHASE) && !dir_dn && !at_max
      |=> cnt == $past(cnt) + ONE);
endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  mode_e        mode,
  input  logic [1:0]   com,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load_evt,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         dir_dn,
  output logic [W-1:0] ocr_act,
  output logic         match_evt,
  output logic         wave
);
  logic [W-1:0] ocr_buf;
  logic         pwm, wv, wv_n;

  assign pwm       = (mode == M_FAST) || (mode == M_PHASE);
  assign match_evt = run && tick && (cnt == ocr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else if (run) begin
      if (wr) ocr_buf <= wdata;
      if (!pwm)          ocr_act <= wr ? wdata : ocr_buf;
      else if (load_evt) ocr_act <= ocr_buf;
    end
  end

  always_comb begin
    wv_n = wv;
    case (mode)
      M_FAST: begin
        if (com[1]) begin
          if (load_evt)       wv_n = ~com[0];
          else if (match_evt) wv_n = com[0];
        end
      end
      M_PHASE: begin
        if (com[1] && match_evt) wv_n = dir_dn ^ com[0];
      end
      default: begin
        if (match_evt) begin
          case (com)
            2'd1:    wv_n = ~wv;
            2'd2:    wv_n = 1'b0;
            2'd3:    wv_n = 1'b1;
            default: wv_n = wv;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wv <= 1'b0;
    else if (run) wv <= wv_n;
  end

  assign wave = wv & (pwm ? com[1] : (com != 2'd0));

  // R5: in PWM modes the active compare value moves only at a period boundary
  p_dbuf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && pwm && !load_evt |=> $stable(ocr_act));
  // R6: non-inverting dual-slope output follows the count direction on a match
  p_phase_sym_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && (mode == M_PHASE) && (com == 2'd2) && match_evt |=> wv == $past(dir_dn));
endmodule

// File: rtl/tmr8_dualcmp.sv
module tmr8_dualcmp
  import tmr8_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_off,
  input  logic [PRE_TAPS-1:0] pre_stb,
  input  logic                ext_pin,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic [CNT_W-1:0]    count,
  output logic                wave_a,
  output logic                wave_b,
  output logic                irq_ovf,
  output logic                irq_cmpa,
  output logic                irq_cmpb
);
  localparam int FLG_W = NCH + 1;

  logic             run, wr_go, tick, dir_dn, ovf_evt, load_evt;
  logic [2:0]       csel;
  mode_e            mode;
  logic [1:0]       com   [NCH];
  logic [CNT_W-1:0] ocr_act [NCH];
  logic [NCH-1:0]   match, wave;
  logic [FLG_W-1:0] flg, flg_set, flg_clr;
  int               addr_i;

  assign run    = ~pwr_off;
  assign wr_go  = run & wr_en;
  assign addr_i = int'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel <= '0;
      mode <= M_NORMAL;
      for (int c = 0; c < NCH; c++) com[c] <= '0;
    end else if (wr_go) begin
      if (addr_i == A_CTRL) begin
        csel <= wr_data[2:0];
        mode <= mode_e'(wr_data[4:3]);
      end
      if (addr_i == A_OUTM)
        for (int c = 0; c < NCH; c++) com[c] <= wr_data[2*c +: 2];
    end
  end

  tmr8_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .csel(csel),
    .pre_stb(pre_stb), .ext_pin(ext_pin), .tick(tick)
  );

  tmr8_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .mode(mode),
    .top_val(ocr_act[0]), .cnt_wr(wr_go && (addr_i == A_CNT)),
    .cnt_wdata(wr_data), .cnt(count), .dir_dn(dir_dn),
    .ovf_evt(ovf_evt), .load_evt(load_evt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr8_cmp #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .com(com[ch]),
      .wr(wr_go && (addr_i == A_CMPA + ch)), .wdata(wr_data),
      .load_evt(load_evt), .tick(tick), .cnt(count), .dir_dn(dir_dn),
      .ocr_act(ocr_act[ch]), .match_evt(match[ch]), .wave(wave[ch])
    );
  end

  assign flg_set = {match, ovf_evt};
  assign flg_clr = (wr_go && (addr_i == A_FLAG)) ? wr_data[FLG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flg <= '0;
    else if (run) flg <= (flg & ~flg_clr) | flg_set;
  end

  assign irq_ovf  = flg[0];
  assign irq_cmpa = flg[1];
  assign irq_cmpb = flg[2];
  assign wave_a   = wave[0];
  assign wave_b   = wave[1];

  // R2: a stopped counter holds unless software loads it
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && (csel == 3'd0) && !(wr_go && (addr_i == A_CNT)) |=> $stable(count));
  // R10: power-down freezes count and flags
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> $stable(count) && $stable(flg));
  // R7: a channel B match raises its flag on the next cycle
  p_cmpb_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && (count == ocr_act[1]) |=> irq_cmpb);
  // R3: a wrap in free counting raises the overflow flag
  p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && (mode == M_NORMAL) && (count == '1) |=> irq_ovf);
endmodule

// File: tb/tmr8_dualcmp_bench.sv
module tmr8_dualcmp_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, pwr_off = 1'b0, ext_pin = 1'b0, wr_en = 1'b0;
  logic [3:0] pre_stb = '0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       wave_a, wave_b, irq_ovf, irq_cmpa, irq_cmpb;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  tmr8_dualcmp u_tmr8_dualcmp (
    .clk(clk), .rst_n(rst_n), .pwr_off(pwr_off), .pre_stb(pre_stb),
    .ext_pin(ext_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .wave_a(wave_a), .wave_b(wave_b),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(int bit_i);
    pre_stb = 4'(1 << bit_i);
    step(1);
    pre_stb = '0;
    step(1);
  endtask

  task automatic t_reset;
    chk("R1 count", int'(count), 0);
    chk("R1 flags", int'({irq_ovf, irq_cmpa, irq_cmpb}), 0);
    chk("R1 pins", int'({wave_a, wave_b}), 0);
  endtask

  task automatic t_normal;
    wr(4, 'hFA);
    wr(0, 1);                      // every clock, mode 0
    step(5);
    chk("R3 before wrap", int'(count), 255);
    chk("R3 no early ovf", int'(irq_ovf), 0);
    step(1);
    chk("R3 wrap", int'(count), 0);
    chk("R3 ovf flag", int'(irq_ovf), 1);
    wr(5, 1);
    chk("R8 ovf cleared", int'(irq_ovf), 0);
  endtask

  task automatic t_sources;
    int c;
    wr(0, 0);
    c = int'(count);
    step(5);
    chk("R2 stopped", int'(count), c);
    wr(4, 0);
    wr(0, 2);                      // strobe bit 0
    strobe(1); strobe(1); strobe(0); strobe(0); strobe(0);
    chk("R2 tap0", int'(count), 3);
    wr(0, 3);                      // strobe bit 1
    strobe(1); strobe(3);
    chk("R2 tap1", int'(count), 4);
    wr(0, 0); wr(4, 0); wr(0, 7);  // rising edges
    for (int i = 0; i < 3; i++) begin
      ext_pin = 1'b1; step(4); ext_pin = 1'b0; step(4);
    end
    chk("R2 rising", int'(count), 3);
    wr(0, 0); wr(4, 0); wr(0, 6);  // falling edges
    for (int i = 0; i < 2; i++) begin
      ext_pin = 1'b1; step(4); ext_pin = 1'b0; step(4);
    end
    chk("R2 falling", int'(count), 2);
  endtask

  task automatic t_ctc;
    wr(0, 0); wr(5, 7);
    wr(1, 'b1101);                 // A toggle, B set
    wr(2, 4); wr(3, 2); wr(4, 0);
    wr(0, 9);                      // mode 1, every clock
    step(3);
    chk("R7 B flag alone", int'({irq_cmpa, irq_cmpb}), 1);
    chk("R9 B set pin", int'(wave_b), 1);
    chk("R4 count", int'(count), 3);
    step(2);
    chk("R4 reload", int'(count), 0);
    chk("R7 A flag", int'(irq_cmpa), 1);
    chk("R9 A toggle on", int'(wave_a), 1);
    step(5);
    chk("R4 period", int'(count), 0);
    chk("R9 A toggle off", int'(wave_a), 0);
  endtask

  task automatic t_flags;
    wr(0, 0);
    wr(5, 0);
    chk("R8 zero keeps", int'({irq_cmpa, irq_cmpb}), 3);
    wr(5, 2);
    chk("R8 clear A only", int'({irq_cmpa, irq_cmpb}), 1);
  endtask

  task automatic t_fast;
    wr(0, 16);                     // mode 2, stopped
    wr(1, 'b1110);                 // A non-inverting, B inverting
    wr(2, 'h40); wr(3, 'h80); wr(5, 7); wr(4, 3);
    wr(0, 17);
    step(2);
    chk("R5 old compare still active", int'(irq_cmpa), 1);
    wr(5, 7);
    step(250);
    chk("R5 wrap count", int'(count), 0);
    chk("R5 wrap ovf", int'(irq_ovf), 1);
    chk("R5 A set on wrap", int'(wave_a), 1);
    chk("R5 B cleared on wrap", int'(wave_b), 0);
    step(64);
    chk("R5 A before match", int'(wave_a), 1);
    step(1);
    chk("R5 A cleared at new value", int'(wave_a), 0);
    step(64);
    chk("R5 B set at new value", int'(wave_b), 1);
  endtask

  task automatic t_phase;
    wr(0, 24);                     // mode 3, stopped
    wr(2, 'h10); wr(5, 7); wr(4, 5);
    wr(0, 25);
    step(250);
    chk("R6 top", int'(count), 255);
    step(1);
    chk("R6 turn down", int'(count), 254);
    chk("R6 no ovf at top", int'(irq_ovf), 0);
    step(190);
    chk("R6 A low before down match", int'(wave_a), 0);
    step(1);
    chk("R6 A set on down match", int'(wave_a), 1);
    step(63);
    chk("R6 bottom", int'(count), 0);
    chk("R6 ovf at bottom", int'(irq_ovf), 1);
    step(16);
    chk("R6 A high before new match", int'(wave_a), 1);
    step(1);
    chk("R6 A cleared at loaded value", int'(wave_a), 0);
  endtask

  task automatic t_cnt_write;
    wr(0, 1);
    wr(4, 'h30);
    chk("R11 load wins", int'(count), 'h30);
    step(1);
    chk("R11 continues", int'(count), 'h31);
  endtask

  task automatic t_power;
    int c;
    pwr_off = 1'b1;
    c = int'(count);
    step(3);
    wr(4, 'h77);
    step(2);
    chk("R10 frozen", int'(count), c);
    pwr_off = 1'b0;
    step(1);
    chk("R10 resumes", int'(count), (c + 1) % 256);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_normal();
    t_sources();
    t_ctc();
    t_flags();
    t_fast();
    t_phase();
    t_cnt_write();
    t_power();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule